// File: doc/BRIEF.md
# Predicated Byte Histogram Unit

This unit counts the bytes of one 64-byte vector into 64 byte-wide bins. The low six bits of each byte name its bin. A byte is counted only when its two top bits equal a 2-bit predicate, which is taken from the low bits of an 8-bit immediate. Each operation counts one quarter of the byte range. Four operations with predicates 0, 1, 2 and 3 on the same vector therefore give a full 256-value histogram.

An operation begins with a one-cycle `start_i` pulse while the unit is idle. The vector and the predicate are captured on that edge. The unit then works through the vector a few lanes at a time. Increments from several lanes that hit the same bin in the same cycle are summed, so none is lost. When the last slice has been counted, the 64 counters are written to `bins_o` together and `done_o` pulses for one cycle. `bins_o` keeps that result until the next operation completes.

Top module: `byte_hist_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `bins_o` is all zero and `done_o` and `busy_o` are low.
- R2: For each input byte, bits [5:0] select the bin. Bin k is held in `bins_o[8k+7:8k]`. The byte adds one to that bin only when its bits [7:6] equal `imm_i[1:0]`.
- R3: Every operation starts from all-zero bins. No count from an earlier operation appears in a later result.
- R4: `imm_i[7:2]` has no effect on the result.
- R5: Bytes that fall in the same bin are all counted, even when several of them arrive in the same cycle. A single bin can reach 64.
- R6: A start accepted at clock edge E raises `busy_o` from E to E+NUM_BYTES/LANES. At that later edge `busy_o` falls and `done_o` rises for exactly one cycle. A start presented in the `done_o` cycle is accepted.
- R7: `start_i` has no effect while `busy_o` is high. The running operation finishes with its own captured vector and predicate, and it produces a single `done_o` pulse.
- R8: `bins_o` changes only in a cycle in which `done_o` is high. Between completions it holds its value, whatever `vec_i`, `imm_i` and `start_i` do.
- R9: For any one vector, the bin totals of the four operations with predicates 0 to 3 add up to 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begins an operation when the unit is idle |
| vec_i | input | NUM_BYTES*8 | Byte vector to count; byte i is at bits [8i+7:8i] |
| imm_i | input | 8 | Immediate; bits [1:0] are the predicate |
| busy_o | output | 1 | High while an operation is counting |
| done_o | output | 1 | One-cycle pulse when a new result is on `bins_o` |
| bins_o | output | 64*CNT_W | 64 bin counters; bin k at bits [CNT_W*k+CNT_W-1:CNT_W*k] |

## Verification
The bench builds the unit with NUM_BYTES=64, LANES=8 and CNT_W=8. This gives an eight-beat operation in which up to eight increments can land on one bin in a single cycle. A vector of 64 identical bytes drives one bin to its largest count, 64. With eight beats per operation there is time to raise `start_i` again mid-run and to check that this second pulse is ignored. Constant, ramp, pseudo-random and clustered vectors cover every predicate value. Some of them cross the predicate boundaries partway through the vector.

// File: rtl/hist_pkg.sv
package hist_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 6;
    localparam int PRED_W = BYTE_W - IDX_W;
    localparam int NBINS  = 1 << IDX_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] bin;
    } lane_tag_t;

    // Split a byte into its bin index and whether its top bits match the predicate.
    function automatic lane_tag_t classify(input logic [BYTE_W-1:0] b,
                                           input logic [PRED_W-1:0] pred);
        lane_tag_t t;
        t.hit = (b[BYTE_W-1:IDX_W] == pred);
        t.bin = b[IDX_W-1:0];
        return t;
    endfunction

endpackage

// File: rtl/hist_seq.sv
module hist_seq
    import hist_pkg::*;
#(
    parameter int BEATS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic load_o,
    output logic step_o,
    output logic last_o
);

    localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

    seq_state_e      state_q;
    logic [BW-1:0]   beat_q;

    assign load_o = (state_q == ST_IDLE) && start_i;
    assign step_o = (state_q == ST_RUN);
    assign last_o = step_o && (beat_q == BW'(BEATS - 1));
    assign busy_o = step_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        beat_q  <= '0;
                    end
                end
                ST_RUN: begin
                    if (last_o) begin
                        state_q <= ST_IDLE;
                        beat_q  <= '0;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hist_lane_decode.sv
module hist_lane_decode
    import hist_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [PRED_W-1:0] pred_i,
    input  logic              en_i,
    output logic [NBINS-1:0]  sel_o
);

    lane_tag_t tag;

    always_comb begin
        tag   = classify(byte_i, pred_i);
        sel_o = '0;
        if (en_i && tag.hit) begin
            sel_o[tag.bin] = 1'b1;
        end
    end

endmodule

// File: rtl/hist_bin_cell.sv
module hist_bin_cell #(
    parameter int LANES = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic [LANES-1:0] col_i,
    output logic [CNT_W-1:0] nxt_o
);

    localparam int INC_W = $clog2(LANES + 1);

    logic [INC_W-1:0] inc;
    logic [CNT_W-1:0] cnt_q;

    // Number of lanes that hit this bin in the current beat.
    always_comb begin
        inc = '0;
        for (int l = 0; l < LANES; l++) begin
            inc = inc + INC_W'(col_i[l]);
        end
    end

    assign nxt_o = cnt_q + CNT_W'(inc);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= nxt_o;
        end
    end

endmodule

// File: rtl/byte_hist_unit.sv
module byte_hist_unit
    import hist_pkg::*;
#(
    parameter int NUM_BYTES = 64,
    parameter int LANES     = 8,
    parameter int CNT_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic [NUM_BYTES*BYTE_W-1:0]   vec_i,
    input  logic [BYTE_W-1:0]             imm_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic [NBINS*CNT_W-1:0]        bins_o
);

    localparam int BEATS  = NUM_BYTES / LANES;
    localparam int VEC_W  = NUM_BYTES * BYTE_W;
    localparam int BEAT_W = LANES * BYTE_W;

    logic load, step, last;

    logic [VEC_W-1:0]  vec_q;
    logic [PRED_W-1:0] pred_q;
    logic              unused_imm_bits;

    logic [NBINS-1:0]  sel [LANES];
    logic [LANES-1:0]  col [NBINS];
    logic [CNT_W-1:0]  nxt [NBINS];

    logic [NBINS*CNT_W-1:0] bins_q;
    logic                   done_q;

    assign unused_imm_bits = ^imm_i[BYTE_W-1:PRED_W];

    hist_seq #(.BEATS(BEATS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .busy_o  (busy_o),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last)
    );

    // Captured operand; each beat shifts the next LANES bytes into the low lanes.
    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q  <= '0;
            pred_q <= '0;
        end else if (load) begin
            vec_q  <= vec_i;
            pred_q <= imm_i[PRED_W-1:0];
        end else if (step) begin
            vec_q  <= vec_q >> BEAT_W;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        hist_lane_decode u_dec (
            .byte_i (vec_q[l*BYTE_W +: BYTE_W]),
            .pred_i (pred_q),
            .en_i   (step),
            .sel_o  (sel[l])
        );
    end

    always_comb begin
        for (int b = 0; b < NBINS; b++) begin
            for (int l = 0; l < LANES; l++) begin
                col[b][l] = sel[l][b];
            end
        end
    end

    for (genvar b = 0; b < NBINS; b++) begin : g_bin
        hist_bin_cell #(.LANES(LANES), .CNT_W(CNT_W)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .clear_i (load),
            .col_i   (col[b]),
            .nxt_o   (nxt[b])
        );
    end

    // Publish the complete set of counters at once on the final beat.
    always_ff @(posedge clk) begin
        if (rst) begin
            bins_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (last) begin
                for (int b = 0; b < NBINS; b++) begin
                    bins_q[b*CNT_W +: CNT_W] <= nxt[b];
                end
            end
        end
    end

    assign bins_o = bins_q;
    assign done_o = done_q;

endmodule

// File: rtl/byte_hist_unit_chk.sv
module byte_hist_unit_chk
    import hist_pkg::*;
#(
    parameter int NUM_BYTES = 64,
    parameter int LANES     = 8,
    parameter int CNT_W     = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start_i,
    input logic                   busy_o,
    input logic                   done_o,
    input logic [NBINS*CNT_W-1:0] bins_o
);

    localparam int BEATS = NUM_BYTES / LANES;

    logic [15:0] run_cnt;
    logic [15:0] total;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 16'd1;
        end else begin
            run_cnt <= '0;
        end
    end

    always_comb begin
        total = '0;
        for (int b = 0; b < NBINS; b++) begin
            total = total + 16'(bins_o[b*CNT_W +: CNT_W]);
        end
    end

    // R6: an accepted start makes the unit busy on the next cycle
    p_busy_after_start_r6: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R6: done is a single-cycle pulse
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: done arrives as busy ends
    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    // R7: a start during a run does not stretch or restart it
    p_run_length_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (run_cnt == 16'(BEATS)));

    // R8: the result only changes together with done
    p_bins_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(bins_o) |-> done_o);

    // R5: no operation can count more bytes than the vector holds
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (total <= 16'(NUM_BYTES)));

endmodule

bind byte_hist_unit byte_hist_unit_chk #(
    .NUM_BYTES (NUM_BYTES),
    .LANES     (LANES),
    .CNT_W     (CNT_W)
) u_chk (.*);

// File: tb/byte_hist_unit_bench.sv
module byte_hist_unit_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NB    = 64;
    localparam int LN    = 8;
    localparam int CW    = 8;
    localparam int BEATS = NB / LN;
    localparam int VW    = NB * 8;
    localparam int OW    = 64 * CW;

    // row: {kind[25:24], seed[23:16], imm[15:8], expected total[7:0]}; total 255 = not tabulated
    localparam int NROWS = 12;
    localparam logic [25:0] TABLE [NROWS] = '{
        {2'd0, 8'h05, 8'h00, 8'd64},
        {2'd0, 8'h05, 8'h01, 8'd0},
        {2'd0, 8'hC0, 8'h03, 8'd64},
        {2'd1, 8'd0,  8'h00, 8'd64},
        {2'd1, 8'd64, 8'h01, 8'd64},
        {2'd1, 8'd32, 8'h00, 8'd32},
        {2'd1, 8'd32, 8'h01, 8'd32},
        {2'd2, 8'd3,  8'h00, 8'd255},
        {2'd2, 8'd3,  8'h02, 8'd255},
        {2'd3, 8'h81, 8'h02, 8'd64},
        {2'd0, 8'h7F, 8'hFD, 8'd64},
        {2'd1, 8'd200, 8'h03, 8'd56}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_r = 1'b0;
    logic [VW-1:0] vec_r = '0;
    logic [7:0]    imm_r = '0;
    logic          busy_o, done_o;
    logic [OW-1:0] bins_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    byte_hist_unit #(.NUM_BYTES(NB), .LANES(LN), .CNT_W(CW)) u_byte_hist_unit (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_r),
        .vec_i   (vec_r),
        .imm_i   (imm_r),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .bins_o  (bins_o)
    );

    task automatic check(input bit ok, input string msg);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic logic [VW-1:0] gen_vec(input logic [1:0] kind, input logic [7:0] seed);
        logic [VW-1:0] v = '0;
        logic [7:0]    x = seed;
        for (int i = 0; i < NB; i++) begin
            case (kind)
                2'd0: v[i*8 +: 8] = seed;
                2'd1: v[i*8 +: 8] = seed + 8'(i);
                2'd2: begin x = x * 8'd37 + 8'd11; v[i*8 +: 8] = x; end
                default: v[i*8 +: 8] = seed + 8'(i % 4);
            endcase
        end
        return v;
    endfunction

    function automatic logic [OW-1:0] model(input logic [VW-1:0] v, input logic [7:0] imm);
        logic [OW-1:0] r = '0;
        for (int i = 0; i < NB; i++) begin
            logic [7:0] b = v[i*8 +: 8];
            if (b[7:6] == imm[1:0]) r[b[5:0]*CW +: CW] = r[b[5:0]*CW +: CW] + 1'b1;
        end
        return r;
    endfunction

    function automatic int total_of(input logic [OW-1:0] r);
        int t = 0;
        for (int b = 0; b < 64; b++) t += int'(r[b*CW +: CW]);
        return t;
    endfunction

    // Caller stands at a negedge; returns at the negedge where done is seen.
    task automatic run_op(input logic [VW-1:0] v, input logic [7:0] imm,
                          output logic [OW-1:0] res, output int lat);
        vec_r = v; imm_r = imm; start_r = 1'b1;
        @(negedge clk);
        start_r = 1'b0;
        lat = 1;
        while (!done_o && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        res = bins_o;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [OW-1:0] res, res2, exp;
        logic [VW-1:0] v;
        int lat, sum, dones;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(bins_o == '0 && !done_o && !busy_o,
              $sformatf("R1 reset state: done=%0b busy=%0b bins_nonzero=%0b exp 0 0 0", done_o, busy_o, |bins_o));
        rst = 1'b0;
        @(negedge clk);
        check(bins_o == '0 && !done_o && !busy_o,
              $sformatf("R1 after reset: done=%0b busy=%0b exp 0 0", done_o, busy_o));

        // Table walk: R2 bins, R5 totals, R6 latency (back-to-back starts)
        for (int r = 0; r < NROWS; r++) begin
            logic [25:0] row = TABLE[r];
            v   = gen_vec(row[25:24], row[23:16]);
            exp = model(v, row[15:8]);
            run_op(v, row[15:8], res, lat);
            check(res == exp, $sformatf("R2 row %0d bins act=%h exp=%h", r, res, exp));
            if (row[7:0] != 8'd255)
                check(total_of(res) == int'(row[7:0]),
                      $sformatf("R5 row %0d total act=%0d exp=%0d", r, total_of(res), row[7:0]));
            check(lat == BEATS + 1, $sformatf("R6 row %0d latency act=%0d exp=%0d", r, lat, BEATS + 1));
        end

        // R5: all 64 bytes in one bin
        run_op(gen_vec(2'd0, 8'h2A), 8'h00, res, lat);
        check(res[42*CW +: CW] == 8'd64, $sformatf("R5 full bin act=%0d exp=64", res[42*CW +: CW]));

        // R3: fresh bins each operation
        run_op(gen_vec(2'd0, 8'h06), 8'h00, res, lat);
        check(res[42*CW +: CW] == 8'd0 && res[6*CW +: CW] == 8'd64,
              $sformatf("R3 bin42 act=%0d exp=0 bin6 act=%0d exp=64", res[42*CW +: CW], res[6*CW +: CW]));

        // R4: upper immediate bits ignored
        v = gen_vec(2'd2, 8'd91);
        run_op(v, 8'h02, res, lat);
        run_op(v, 8'hFE, res2, lat);
        check(res == res2 && res == model(v, 8'h02),
              $sformatf("R4 imm FE act=%h exp=%h", res2, res));

        // R8: output holds between completions
        res = bins_o;
        vec_r = gen_vec(2'd2, 8'd7); imm_r = 8'h01;
        dones = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done_o) dones++;
        end
        check(bins_o == res && dones == 0,
              $sformatf("R8 idle hold changed=%0b dones=%0d exp 0 0", bins_o != res, dones));
        // R8: old result visible during a run
        v = gen_vec(2'd1, 8'd10);
        vec_r = v; imm_r = 8'h00; start_r = 1'b1;
        @(negedge clk); start_r = 1'b0;
        repeat (3) @(negedge clk);
        check(bins_o == res && busy_o, $sformatf("R8 hold mid-run changed=%0b busy=%0b exp 0 1", bins_o != res, busy_o));
        while (!done_o) @(negedge clk);
        check(bins_o == model(v, 8'h00), $sformatf("R8 new result act=%h exp=%h", bins_o, model(v, 8'h00)));

        // R7: start while busy ignored
        v = gen_vec(2'd2, 8'd55);
        vec_r = v; imm_r = 8'h01; start_r = 1'b1;
        @(negedge clk); start_r = 1'b0;
        @(negedge clk);
        vec_r = gen_vec(2'd0, 8'h41); imm_r = 8'h01; start_r = 1'b1;
        @(negedge clk); start_r = 1'b0;
        lat = 3; dones = 0;
        while (!done_o && lat < 100) begin @(negedge clk); lat++; end
        res = bins_o;
        for (int i = 0; i < 12; i++) begin
            if (done_o) dones++;
            @(negedge clk);
        end
        check(res == model(v, 8'h01), $sformatf("R7 result act=%h exp=%h", res, model(v, 8'h01)));
        check(lat == BEATS + 1 && dones == 1 && !busy_o,
              $sformatf("R7 latency=%0d dones=%0d busy=%0b exp %0d 1 0", lat, dones, busy_o, BEATS + 1));

        // R9: four predicates cover every byte
        v = gen_vec(2'd2, 8'd200);
        sum = 0;
        for (int p = 0; p < 4; p++) begin
            run_op(v, 8'(p), res, lat);
            sum += total_of(res);
        end
        check(sum == NB, $sformatf("R9 coverage total act=%0d exp=%0d", sum, NB));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule